// File: doc/BRIEF.md
# Precision Time System Clock

This block keeps the system time for a precision time protocol node. The time has a 32-bit seconds field and a 32-bit sub-seconds field. On every reference tick the sub-seconds grow by a programmed increment. The sub-seconds wrap at either a decimal-nanosecond limit or a binary limit, and each wrap carries one into the seconds. There are two ways to advance the time:
- **Coarse**: the increment is applied on every tick.
- **Fine**: a 32-bit accumulator adds an active addend value on each tick. The increment is applied only on the ticks where that accumulator carries out, which lets software trim the rate.

Software drives the block through a flat write/read register port. Three self-clearing commands change the time or the rate:
- **Load**: overwrite the time.
- **Step**: add a signed offset to the time.
- **Addend transfer**: copy a new addend into the fine-rate path.

A self-disarming comparator raises a one-cycle interrupt the first time the running time passes a programmed target.

Top module: `ptp_systime`

## Requirements
- R1: After a synchronous reset, every register and the active addend are zero, the time reads 0 s / 0, and `irq` is low.
- R2: Register map (byte-free word addresses):
  - 0 = control, with run in bit 0, fine in bit 1, decimal-wrap in bit 2, load in bit 3, step in bit 4, addend transfer in bit 5 and trigger arm in bit 6.
  - 1 = increment, 2 = offset seconds, 3 = offset sub-seconds, 4 = programmed addend, 5 = target seconds, 6 = target sub-seconds.
  - 7 = active addend, read only.

  `rd_data` shows the addressed word combinationally. With run set and coarse mode selected, every clock edge with `tick_en` high adds the increment to the sub-seconds.
- R3: While run is 0, or on edges with `tick_en` low, the time does not change except through a load or step command.
- R4: With decimal-wrap 0, a sub-second sum of 0x8000_0000 or more has 0x8000_0000 subtracted from it and carries one into the seconds.
- R5: With decimal-wrap 1, a sub-second sum of 1,000,000,000 or more has 1,000,000,000 subtracted from it, so the last value kept is 0x3B9A_C9FF, and carries one into the seconds.
- R6: A write of 1 to control bit 3 makes that bit read 1 for exactly one cycle. At the next edge it returns to 0, and the time becomes the offset seconds with sub-seconds equal to bits 30:0 of word 3. No tick is applied on that edge.
- R7: A step command (control bit 4) with bit 31 of word 3 clear adds the offset seconds and bits 30:0 of word 3 to the time, with wrap and carry under the current mode. No tick is applied on that edge.
- R8: A step with bit 31 of word 3 set subtracts instead. If the sub-second result would be negative, the modulus is added to it and one extra second is taken away.
- R9: In fine mode, each ticked edge adds the active addend to a 32-bit accumulator. The increment is applied only when that addition carries out of bit 31.
- R10: An addend transfer (control bit 5) copies word 4 into the active addend on the edge after the write, and the bit then self-clears. The tick on that edge still uses the old active addend.
- R11: Only one command is pending at a time. A write that sets command bits while one is pending is ignored for those bits. Within a single write, load beats step, and step beats addend transfer.
- R12: When arm is set and the time is strictly greater than the target (seconds compared first, then sub-seconds), `irq` goes high for one cycle on the next edge and arm clears. If the time equals the target, nothing fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data for `rd_addr` |
| tick_en | input | 1 | Reference tick enable |
| time_sec | output | 32 | System time, seconds |
| time_sub | output | 32 | System time, sub-seconds |
| irq | output | 1 | Target-time interrupt pulse |

## Verification
A wrong sub-second or accumulator value shows on `time_sec`/`time_sub` at the first ticked edge that depends on it, and a missed wrap or borrow shows as a one-second error at once. A stuck pending command bit is visible on the control word the cycle after the write, and it also blocks the next command. A wrong arm or compare shows as an `irq` pulse missing or extra on the edge after the time crosses the target. A reference model is compared against every port on every cycle, so any of these appears within one clock of the divergence.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

    localparam int SEC_W  = 32;
    localparam int SUB_W  = 32;
    localparam int ACC_W  = 32;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [SUB_W:0] MOD_DECIMAL = 33'd1_000_000_000;
    localparam logic [SUB_W:0] MOD_BINARY  = 33'h0_8000_0000;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_INC  = 3'd1;
    localparam logic [ADDR_W-1:0] A_OSEC = 3'd2;
    localparam logic [ADDR_W-1:0] A_OSUB = 3'd3;
    localparam logic [ADDR_W-1:0] A_ADD  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TSEC = 3'd5;
    localparam logic [ADDR_W-1:0] A_TSUB = 3'd6;
    localparam logic [ADDR_W-1:0] A_ACT  = 3'd7;

    localparam int B_RUN  = 0;
    localparam int B_FINE = 1;
    localparam int B_DEC  = 2;
    localparam int B_LOAD = 3;
    localparam int B_STEP = 4;
    localparam int B_XFER = 5;
    localparam int B_ARM  = 6;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } ptp_time_t;

    typedef struct packed {
        logic run;
        logic fine;
        logic dec;
        logic arm;
    } ctrl_t;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2,
        CMD_XFER = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [SUB_W-1:0]  inc;
        logic [SEC_W-1:0]  osec;
        logic [SUB_W-1:0]  osub;
        logic [DATA_W-1:0] addend;
        logic [SEC_W-1:0]  tsec;
        logic [SUB_W-1:0]  tsub;
    } cfg_t;

    function automatic logic [SUB_W:0] wrap_mod(input logic dec);
        return dec ? MOD_DECIMAL : MOD_BINARY;
    endfunction

    function automatic ptp_time_t time_advance(input ptp_time_t t,
                                               input logic [SUB_W-1:0] inc,
                                               input logic dec);
        logic [SUB_W:0] s;
        logic [SUB_W:0] m;
        ptp_time_t r;
        m = wrap_mod(dec);
        s = {1'b0, t.sub} + {1'b0, inc};
        r = t;
        if (s >= m) begin
            s     = s - m;
            r.sec = t.sec + 1'b1;
        end
        r.sub = s[SUB_W-1:0];
        return r;
    endfunction

    function automatic ptp_time_t time_step(input ptp_time_t t,
                                            input logic [SEC_W-1:0] osec,
                                            input logic [SUB_W-1:0] osub,
                                            input logic dec);
        logic [SUB_W:0] s;
        logic [SUB_W:0] m;
        logic [SUB_W:0] mag;
        ptp_time_t r;
        m   = wrap_mod(dec);
        mag = {2'b00, osub[SUB_W-2:0]};
        if (!osub[SUB_W-1]) begin
            s = {1'b0, t.sub} + mag;
            if (s >= m) begin
                s     = s - m;
                r.sec = t.sec + osec + 1'b1;
            end else begin
                r.sec = t.sec + osec;
            end
        end else begin
            if ({1'b0, t.sub} >= mag) begin
                s     = {1'b0, t.sub} - mag;
                r.sec = t.sec - osec;
            end else begin
                s     = {1'b0, t.sub} + m - mag;
                r.sec = t.sec - osec - 1'b1;
            end
        end
        r.sub = s[SUB_W-1:0];
        return r;
    endfunction

    function automatic logic time_after(input ptp_time_t a, input ptp_time_t b);
        return (a.sec > b.sec) || ((a.sec == b.sec) && (a.sub > b.sub));
    endfunction

endpackage

// File: rtl/ptp_regs.sv
module ptp_regs
    import ptp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              fire,
    input  logic [ACC_W-1:0]  act_addend,
    output ctrl_t             ctrl,
    output cmd_e              pend,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] rd_data
);

    logic ctrl_wr;
    cmd_e req;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    // Priority among command bits of a single control write
    always_comb begin
        req = CMD_IDLE;
        if (ctrl_wr) begin
            if (wr_data[B_LOAD])      req = CMD_LOAD;
            else if (wr_data[B_STEP]) req = CMD_STEP;
            else if (wr_data[B_XFER]) req = CMD_XFER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            pend <= CMD_IDLE;
            cfg  <= '0;
        end else begin
            if (fire) ctrl.arm <= 1'b0;
            if (ctrl_wr) begin
                ctrl.run  <= wr_data[B_RUN];
                ctrl.fine <= wr_data[B_FINE];
                ctrl.dec  <= wr_data[B_DEC];
                ctrl.arm  <= wr_data[B_ARM];
            end
            // a pending command executes this edge; new requests wait for idle
            pend <= (pend != CMD_IDLE) ? CMD_IDLE : req;
            if (wr_en) begin
                case (wr_addr)
                    A_INC:   cfg.inc    <= wr_data;
                    A_OSEC:  cfg.osec   <= wr_data;
                    A_OSUB:  cfg.osub   <= wr_data;
                    A_ADD:   cfg.addend <= wr_data;
                    A_TSEC:  cfg.tsec   <= wr_data;
                    A_TSUB:  cfg.tsub   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[B_RUN]  = ctrl.run;
                rd_data[B_FINE] = ctrl.fine;
                rd_data[B_DEC]  = ctrl.dec;
                rd_data[B_LOAD] = (pend == CMD_LOAD);
                rd_data[B_STEP] = (pend == CMD_STEP);
                rd_data[B_XFER] = (pend == CMD_XFER);
                rd_data[B_ARM]  = ctrl.arm;
            end
            A_INC:   rd_data = cfg.inc;
            A_OSEC:  rd_data = cfg.osec;
            A_OSUB:  rd_data = cfg.osub;
            A_ADD:   rd_data = cfg.addend;
            A_TSEC:  rd_data = cfg.tsec;
            A_TSUB:  rd_data = cfg.tsub;
            default: rd_data = act_addend;
        endcase
    end

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             run,
    input  logic             fine,
    input  logic             dec,
    input  cmd_e             pend,
    input  logic [SUB_W-1:0] inc,
    input  logic [SEC_W-1:0] osec,
    input  logic [SUB_W-1:0] osub,
    input  logic [ACC_W-1:0] addend,
    output ptp_time_t        now,
    output logic [ACC_W-1:0] act_addend
);

    logic             tick;
    logic             hold;
    logic             bump;
    logic [ACC_W:0]   acc_sum;
    logic [ACC_W-1:0] acc;
    ptp_time_t        nxt;

    assign tick    = run && tick_en;
    assign hold    = (pend == CMD_LOAD) || (pend == CMD_STEP);
    assign acc_sum = {1'b0, acc} + {1'b0, act_addend};
    assign bump    = fine ? acc_sum[ACC_W] : 1'b1;

    always_comb begin
        nxt = now;
        case (pend)
            CMD_LOAD: begin
                nxt.sec = osec;
                nxt.sub = {1'b0, osub[SUB_W-2:0]};
            end
            CMD_STEP: nxt = time_step(now, osec, osub, dec);
            default: begin
                if (tick && bump) nxt = time_advance(now, inc, dec);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now        <= '0;
            acc        <= '0;
            act_addend <= '0;
        end else begin
            now <= nxt;
            if (tick && !hold && fine) acc <= acc_sum[ACC_W-1:0];
            if (pend == CMD_XFER) act_addend <= addend;
        end
    end

endmodule

// File: rtl/ptp_trigger.sv
module ptp_trigger
    import ptp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  ptp_time_t        now,
    input  logic [SEC_W-1:0] tsec,
    input  logic [SUB_W-1:0] tsub,
    output logic             fire,
    output logic             irq
);

    ptp_time_t tgt;

    assign tgt.sec = tsec;
    assign tgt.sub = tsub;
    assign fire    = arm && time_after(now, tgt);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= fire;
    end

endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
    import ptp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick_en,
    output logic [SEC_W-1:0]  time_sec,
    output logic [SUB_W-1:0]  time_sub,
    output logic              irq
);

    ctrl_t            ctrl;
    cmd_e             pend;
    cfg_t             cfg;
    ptp_time_t        now;
    logic [ACC_W-1:0] act_addend;
    logic             fire;

    ptp_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .fire       (fire),
        .act_addend (act_addend),
        .ctrl       (ctrl),
        .pend       (pend),
        .cfg        (cfg),
        .rd_data    (rd_data)
    );

    ptp_time_core u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .run        (ctrl.run),
        .fine       (ctrl.fine),
        .dec        (ctrl.dec),
        .pend       (pend),
        .inc        (cfg.inc),
        .osec       (cfg.osec),
        .osub       (cfg.osub),
        .addend     (cfg.addend),
        .now        (now),
        .act_addend (act_addend)
    );

    ptp_trigger u_trig (
        .clk  (clk),
        .rst  (rst),
        .arm  (ctrl.arm),
        .now  (now),
        .tsec (cfg.tsec),
        .tsub (cfg.tsub),
        .fire (fire),
        .irq  (irq)
    );

    assign time_sec = now.sec;
    assign time_sub = now.sub;

endmodule

// File: rtl/ptp_systime_chk.sv
module ptp_systime_chk
    import ptp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       pend,
    input logic             run,
    input logic             arm,
    input logic             tick_en,
    input logic [SEC_W-1:0] time_sec,
    input logic [SUB_W-1:0] time_sub,
    input logic [SEC_W-1:0] osec,
    input logic [SUB_W-1:0] osub,
    input logic [SEC_W-1:0] tsec,
    input logic [SUB_W-1:0] tsub,
    input logic             irq
);

    a_r11_single_pending: assert property (@(posedge clk) disable iff (rst)
        (pend != 2'd0) |=> (pend == 2'd0));

    a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
        (pend == 2'd1) |=> (time_sec == $past(osec)) &&
                           (time_sub == {1'b0, $past(osub[SUB_W-2:0])}));

    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && pend == 2'd0) |=> ($stable(time_sec) && $stable(time_sub)));

    a_r3_no_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && pend == 2'd0) |=> ($stable(time_sec) && $stable(time_sub)));

    a_r12_fire_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(arm) &&
                (($past(time_sec) > $past(tsec)) ||
                 (($past(time_sec) == $past(tsec)) && ($past(time_sub) > $past(tsub)))));

endmodule

bind ptp_systime ptp_systime_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend),
    .run      (ctrl.run),
    .arm      (ctrl.arm),
    .tick_en  (tick_en),
    .time_sec (time_sec),
    .time_sub (time_sub),
    .osec     (cfg.osec),
    .osub     (cfg.osub),
    .tsec     (cfg.tsec),
    .tsub     (cfg.tsub),
    .irq      (irq)
);

// File: tb/tb_ptp_systime.sv
module tb_ptp_systime;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tick_en = 1'b0;
    logic [31:0] time_sec;
    logic [31:0] time_sub;
    logic        irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    int    tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit    done = 0;

    always #4 clk = ~clk;

    ptp_systime dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_en(tick_en),
        .time_sec(time_sec), .time_sub(time_sub), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_sec, m_sub, m_inc, m_osec, m_osub, m_add, m_tsec, m_tsub, m_act, m_acc;
    bit m_run, m_fine, m_dec, m_arm, m_irq;
    int m_pend;

    function automatic longint modv(bit d);
        return d ? 64'd1000000000 : 64'd2147483648;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_sub = 0; m_inc = 0; m_osec = 0; m_osub = 0; m_add = 0;
            m_tsec = 0; m_tsub = 0; m_act = 0; m_acc = 0;
            m_run = 0; m_fine = 0; m_dec = 0; m_arm = 0; m_irq = 0; m_pend = 0;
        end else begin
            longint md, s, mag;
            bit fire, tick, carry;
            int old_pend, req;
            md = modv(m_dec);
            fire = m_arm && ({m_sec, m_sub} > {m_tsec, m_tsub});
            tick = m_run && tick_en;
            old_pend = m_pend;
            if (old_pend == 1) begin
                m_sec = m_osec;
                m_sub = {1'b0, m_osub[30:0]};
            end else if (old_pend == 2) begin
                mag = longint'(m_osub[30:0]);
                if (!m_osub[31]) begin
                    s = longint'(m_sub) + mag;
                    if (s >= md) begin s = s - md; m_sec = m_sec + m_osec + 1; end
                    else m_sec = m_sec + m_osec;
                end else begin
                    s = longint'(m_sub) - mag;
                    if (s < 0) begin s = s + md; m_sec = m_sec - m_osec - 1; end
                    else m_sec = m_sec - m_osec;
                end
                m_sub = s[31:0];
            end else if (tick) begin
                carry = 1;
                if (m_fine) begin
                    s = longint'(m_acc) + longint'(m_act);
                    carry = (s >= 64'h1_0000_0000);
                    m_acc = s[31:0];
                end
                if (carry) begin
                    s = longint'(m_sub) + longint'(m_inc);
                    if (s >= md) begin s = s - md; m_sec = m_sec + 1; end
                    m_sub = s[31:0];
                end
            end
            if (old_pend == 3) m_act = m_add;
            m_irq = fire;
            if (fire) m_arm = 0;
            req = 0;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin
                        m_run = wr_data[0]; m_fine = wr_data[1]; m_dec = wr_data[2];
                        m_arm = wr_data[6];
                        req = wr_data[3] ? 1 : wr_data[4] ? 2 : wr_data[5] ? 3 : 0;
                    end
                    3'd1: m_inc  = wr_data;
                    3'd2: m_osec = wr_data;
                    3'd3: m_osub = wr_data;
                    3'd4: m_add  = wr_data;
                    3'd5: m_tsec = wr_data;
                    3'd6: m_tsub = wr_data;
                    default: ;
                endcase
            end
            m_pend = (old_pend != 0) ? 0 : req;
        end
    end

    function automatic logic [31:0] model_read(logic [2:0] a);
        case (a)
            3'd0: return {25'd0, m_arm, m_pend == 3, m_pend == 2, m_pend == 1, m_dec, m_fine, m_run};
            3'd1: return m_inc;
            3'd2: return m_osec;
            3'd3: return m_osub;
            3'd4: return m_add;
            3'd5: return m_tsec;
            3'd6: return m_tsub;
            default: return m_act;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!done) begin
            check("time_sec", time_sec, m_sec);
            check("time_sub", time_sub, m_sub);
            check("irq", {31'd0, irq}, {31'd0, m_irq});
            check("rd_data", rd_data, model_read(rd_addr));
        end
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en <= (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? lfsr[0] : 1'b0;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        rst = 1'b0;
        rd_addr = 3'd0; idle(2);
        rd_addr = 3'd7; idle(1);

        // R2: coarse advance with irregular ticks
        cur_req = "R2";
        rd_addr = 3'd1;
        wr(3'd1, 32'd10);
        wr(3'd0, 32'h1);
        tick_mode = 2;
        idle(20);

        // R3: frozen while run is low
        cur_req = "R3";
        wr(3'd0, 32'h0);
        idle(10);

        // R6: load command, pending bit visible one cycle
        cur_req = "R6";
        rd_addr = 3'd0;
        wr(3'd3, 32'hFFFF_FFF0);
        wr(3'd2, 32'd5);
        wr(3'd0, 32'h8);
        idle(2);

        // R4: binary wrap
        cur_req = "R4";
        tick_mode = 1;
        wr(3'd0, 32'h1);
        idle(5);

        // R5: decimal wrap
        cur_req = "R5";
        wr(3'd0, 32'h0);
        wr(3'd1, 32'd7);
        wr(3'd3, 32'd999_999_990);
        wr(3'd2, 32'd100);
        wr(3'd0, 32'h4 | 32'h8);
        wr(3'd0, 32'h5);
        idle(6);

        // R7: positive step
        cur_req = "R7";
        wr(3'd2, 32'd3);
        wr(3'd3, 32'd500_000_000);
        wr(3'd0, 32'h5 | 32'h10);
        idle(3);

        // R8: negative step with borrow
        cur_req = "R8";
        wr(3'd0, 32'h4);
        wr(3'd3, 32'd100);
        wr(3'd2, 32'd50);
        wr(3'd0, 32'h4 | 32'h8);
        wr(3'd3, 32'h8000_0000 | 32'd900_000_000);
        wr(3'd2, 32'd1);
        wr(3'd0, 32'h5 | 32'h10);
        idle(3);

        // R10: addend transfer
        cur_req = "R10";
        rd_addr = 3'd7;
        wr(3'd4, 32'h8000_0000);
        wr(3'd0, 32'h5 | 32'h20);
        idle(2);

        // R9: fine mode with two addend rates
        cur_req = "R9";
        tick_mode = 2;
        wr(3'd0, 32'h7);
        idle(20);
        wr(3'd4, 32'h4000_0001);
        wr(3'd0, 32'h7 | 32'h20);
        idle(20);

        // R11: collisions and in-write priority
        cur_req = "R11";
        rd_addr = 3'd0;
        tick_mode = 0;
        wr(3'd0, 32'h4);
        wr(3'd2, 32'd77);
        wr(3'd3, 32'h10);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h4 | 32'h8;
        @(negedge clk);
        wr_data = 32'h4 | 32'h10;
        @(negedge clk);
        wr_en = 1'b0;
        idle(2);
        wr(3'd0, 32'h4 | 32'h8 | 32'h10);
        idle(2);
        wr(3'd4, 32'h1234_5678);
        wr(3'd0, 32'h4 | 32'h10 | 32'h20);
        idle(2);
        rd_addr = 3'd7;
        idle(2);

        // R12: trigger equal (no fire), then greater, then self-disarm
        cur_req = "R12";
        rd_addr = 3'd0;
        wr(3'd5, m_sec);
        wr(3'd6, m_sub);
        wr(3'd0, 32'h40);
        idle(5);
        wr(3'd6, m_sub - 32'd1);
        idle(5);
        wr(3'd6, m_sub + 32'd50);
        tick_mode = 1;
        wr(3'd0, 32'h40 | 32'h1);
        idle(20);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule